// File: doc/BRIEF.md
# Memory Operation Ordering Queue

This block keeps every in-flight memory operation of an out-of-order core in a single ring, oldest at the head. Each operation is a load, a store, or one of three barrier kinds: a load barrier, a store barrier, or a full barrier that orders both loads and stores. A load takes a load slot and a store takes a store slot. Both kinds share the ring, and a barrier takes a ring slot of its own. Each cycle the block looks at all live entries and decides which memory operations may go to execution without breaking the ordering rules. It grants the oldest of them, up to a fixed number per cycle.

The dispatch stage allocates entries and receives the tag of the slot that was filled. Operand-ready and completion notices come in by tag. The commit stage frees entries strictly from the head. A configuration bit selects no-alias mode. In that mode loads may overtake older stores. With the bit cleared, a load waits until every older store has issued. A barrier does no work of its own: it counts as executed once it reaches the head.

Top module: `memord_queue`

## Requirements
- R1: Loads, stores and barriers are each limited by their own capacity. `lq_full` is high while LQ_DEPTH loads are held, `sq_full` while SQ_DEPTH stores are held, and `ring_full` while all LQ_DEPTH+SQ_DEPTH slots are held. An allocation whose kind meets a full condition is ignored, and `alloc_tag` then stays on the same slot.
- R2: A load never waits for an older load. Several loads behind the same blocker become permitted in the same cycle.
- R3: After reset no-alias mode is on, and a load may issue ahead of an older store that has not issued. After `cfg_we` writes 0, a load is not permitted while any older store is unissued.
- R4: In either mode, a store is not permitted while any older load or store is unissued.
- R5: A barrier counts as executed only while it sits at the head. A load waits for every older load barrier or full barrier that is not at the head. A store waits for every older store barrier or full barrier that is not at the head. A load is not held by a store barrier, and a store is not held by a load barrier.
- R6: `issue_grant` holds at most ISSUE_W bits and only bits that are permitted. It picks from the oldest entry forward, and each entry is granted exactly once.
- R7: `retire_ok` is high when the head entry is a barrier or a completed memory operation. A `retire_valid` pulse then frees the head and advances it. A pulse while `retire_ok` is low is ignored. A completion for an entry that has not issued is also ignored.
- R8: A memory operation is permitted only once its operands are ready. Readiness comes either from `alloc_ops_rdy` at allocation or from a later operand-ready notice.
- R9: Kind encoding is 0 load, 1 store, 2 load barrier, 3 store barrier, 4 full barrier, and other codes are not allocated. Slots are numbered 0 to LQ_DEPTH+SQ_DEPTH-1 and are filled in rising order with wrap-around. Bit n of `issue_perm` and `issue_grant` refers to slot n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the no-alias mode bit |
| cfg_noalias | input | 1 | New no-alias mode value |
| alloc_valid | input | 1 | Allocate one entry this cycle |
| alloc_kind | input | 3 | Kind of the entry being allocated |
| alloc_ops_rdy | input | 1 | Operands already ready at allocation |
| alloc_tag | output | IDX_W | Slot the next allocation fills |
| lq_full | output | 1 | Load capacity used up |
| sq_full | output | 1 | Store capacity used up |
| ring_full | output | 1 | Every ring slot occupied |
| opr_valid | input | 1 | Operand-ready notice |
| opr_tag | input | IDX_W | Slot whose operands became ready |
| cmpl_valid | input | 1 | Completion notice |
| cmpl_tag | input | IDX_W | Slot that completed |
| issue_perm | output | RING | Entries that may issue now |
| issue_grant | output | RING | Entries sent to execution this cycle |
| retire_valid | input | 1 | Request to free the head entry |
| retire_ok | output | 1 | Head entry may be freed |

## Verification
The bench builds the block with LQ_DEPTH 3, SQ_DEPTH 2 and ISSUE_W 2. This gives a five-slot ring whose size is not a power of two, so the head and tail pointers wrap through an irregular boundary within a few operations. The load limit, the store limit and the whole-ring limit can each be reached after two to five allocations. Three loads held behind one store exceed the per-cycle issue width, which makes the oldest-first cut-off visible on the grant vector.

// File: rtl/memord_pkg.sv
package memord_pkg;

    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_LBAR  = 3'd2,
        OP_SBAR  = 3'd3,
        OP_FBAR  = 3'd4
    } op_kind_e;

    function automatic logic kind_is_barrier(input logic [2:0] k);
        return (k == OP_LBAR) || (k == OP_SBAR) || (k == OP_FBAR);
    endfunction

    function automatic logic kind_is_memop(input logic [2:0] k);
        return (k == OP_LOAD) || (k == OP_STORE);
    endfunction

    function automatic logic kind_legal(input logic [2:0] k);
        return k <= OP_FBAR;
    endfunction

    // Barrier kinds that hold back younger loads
    function automatic logic kind_fences_loads(input logic [2:0] k);
        return (k == OP_LBAR) || (k == OP_FBAR);
    endfunction

    // Barrier kinds that hold back younger stores
    function automatic logic kind_fences_stores(input logic [2:0] k);
        return (k == OP_SBAR) || (k == OP_FBAR);
    endfunction

endpackage

// File: rtl/memord_age.sv
module memord_age #(
    parameter int RING  = 8,
    parameter int IDX_W = 3
) (
    input  logic [IDX_W-1:0]            head,
    output logic [RING-1:0][IDX_W-1:0]  age
);

    // Age of a slot = distance from the head, going forward around the ring
    for (genvar g = 0; g < RING; g++) begin : g_slot
        logic [IDX_W:0] raw;
        assign raw = (IDX_W+1)'(g) + (IDX_W+1)'(RING) - {1'b0, head};
        assign age[g] = (raw >= (IDX_W+1)'(RING)) ? IDX_W'(raw - (IDX_W+1)'(RING))
                                                  : IDX_W'(raw);
    end

endmodule

// File: rtl/memord_perm.sv
module memord_perm
    import memord_pkg::*;
#(
    parameter int RING  = 8,
    parameter int IDX_W = 3
) (
    input  logic [RING-1:0]             vld,
    input  logic [RING-1:0]             rdy,
    input  logic [RING-1:0]             iss,
    input  logic [RING-1:0][2:0]        kind,
    input  logic [RING-1:0][IDX_W-1:0]  age,
    input  logic                        noalias,
    output logic [RING-1:0]             perm
);

    logic [RING-1:0] blocked;

    always_comb begin
        blocked = '0;
        for (int i = 0; i < RING; i++) begin
            for (int j = 0; j < RING; j++) begin
                if (j != i && vld[j] && (age[j] < age[i])) begin
                    if (kind[i] == OP_LOAD) begin
                        // barrier not yet at the head has not executed
                        if (kind_fences_loads(kind[j]) && (age[j] != '0))
                            blocked[i] = 1'b1;
                        if (kind[j] == OP_STORE && !iss[j] && !noalias)
                            blocked[i] = 1'b1;
                    end else if (kind[i] == OP_STORE) begin
                        if (kind_is_memop(kind[j]) && !iss[j])
                            blocked[i] = 1'b1;
                        if (kind_fences_stores(kind[j]) && (age[j] != '0))
                            blocked[i] = 1'b1;
                    end
                end
            end
        end
        for (int i = 0; i < RING; i++) begin
            perm[i] = vld[i] && rdy[i] && !iss[i] && kind_is_memop(kind[i]) && !blocked[i];
        end
    end

endmodule

// File: rtl/memord_pick.sv
module memord_pick #(
    parameter int RING    = 8,
    parameter int IDX_W   = 3,
    parameter int ISSUE_W = 2
) (
    input  logic [IDX_W-1:0] head,
    input  logic [RING-1:0]  perm,
    output logic [RING-1:0]  grant
);

    logic [IDX_W:0] slot;
    int             taken;

    // Walk from the head forward; the first ISSUE_W permitted slots win
    always_comb begin
        grant = '0;
        taken = 0;
        slot  = '0;
        for (int a = 0; a < RING; a++) begin
            slot = {1'b0, head} + (IDX_W+1)'(a);
            if (slot >= (IDX_W+1)'(RING))
                slot = slot - (IDX_W+1)'(RING);
            if (perm[slot[IDX_W-1:0]] && (taken < ISSUE_W)) begin
                grant[slot[IDX_W-1:0]] = 1'b1;
                taken = taken + 1;
            end
        end
    end

endmodule

// File: rtl/memord_queue.sv
module memord_queue
    import memord_pkg::*;
#(
    parameter  int LQ_DEPTH = 4,
    parameter  int SQ_DEPTH = 4,
    parameter  int ISSUE_W  = 2,
    localparam int RING     = LQ_DEPTH + SQ_DEPTH,
    localparam int IDX_W    = (RING > 1) ? $clog2(RING) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_noalias,
    input  logic             alloc_valid,
    input  logic [2:0]       alloc_kind,
    input  logic             alloc_ops_rdy,
    output logic [IDX_W-1:0] alloc_tag,
    output logic             lq_full,
    output logic             sq_full,
    output logic             ring_full,
    input  logic             opr_valid,
    input  logic [IDX_W-1:0] opr_tag,
    input  logic             cmpl_valid,
    input  logic [IDX_W-1:0] cmpl_tag,
    output logic [RING-1:0]  issue_perm,
    output logic [RING-1:0]  issue_grant,
    input  logic             retire_valid,
    output logic             retire_ok
);

    localparam int CNT_W = $clog2(RING + 1);
    localparam int LQ_W  = $clog2(LQ_DEPTH + 1);
    localparam int SQ_W  = $clog2(SQ_DEPTH + 1);

    typedef struct packed {
        logic [RING-1:0]       vld;
        logic [RING-1:0]       rdy;
        logic [RING-1:0]       iss;
        logic [RING-1:0]       dne;
        logic [RING-1:0][2:0]  kind;
        logic [IDX_W-1:0]      head;
        logic [IDX_W-1:0]      tail;
        logic [CNT_W-1:0]      cnt;
        logic [LQ_W-1:0]       lcnt;
        logic [SQ_W-1:0]       scnt;
        logic                  noalias;
    } state_t;

    state_t state_d, state_q;

    logic [RING-1:0][IDX_W-1:0] age;
    logic [IDX_W-1:0]           head_idx;
    logic [2:0]                 head_kind;
    logic                       alloc_take;
    logic                       retire_take;
    logic                       take_load, take_store;
    logic                       free_load, free_store;

    function automatic logic [IDX_W-1:0] ptr_next(input logic [IDX_W-1:0] p);
        return (p == IDX_W'(RING - 1)) ? '0 : p + 1'b1;
    endfunction

    function automatic logic tag_in_range(input logic [IDX_W-1:0] t);
        return {1'b0, t} < (IDX_W+1)'(RING);
    endfunction

    memord_age #(
        .RING  (RING),
        .IDX_W (IDX_W)
    ) u_age (
        .head (state_q.head),
        .age  (age)
    );

    memord_perm #(
        .RING  (RING),
        .IDX_W (IDX_W)
    ) u_perm (
        .vld     (state_q.vld),
        .rdy     (state_q.rdy),
        .iss     (state_q.iss),
        .kind    (state_q.kind),
        .age     (age),
        .noalias (state_q.noalias),
        .perm    (issue_perm)
    );

    memord_pick #(
        .RING    (RING),
        .IDX_W   (IDX_W),
        .ISSUE_W (ISSUE_W)
    ) u_pick (
        .head  (state_q.head),
        .perm  (issue_perm),
        .grant (issue_grant)
    );

    assign head_idx  = state_q.head;
    assign head_kind = state_q.kind[state_q.head];
    assign alloc_tag = state_q.tail;
    assign lq_full   = (state_q.lcnt == LQ_W'(LQ_DEPTH));
    assign sq_full   = (state_q.scnt == SQ_W'(SQ_DEPTH));
    assign ring_full = (state_q.cnt  == CNT_W'(RING));
    assign retire_ok = state_q.vld[state_q.head] &&
                       (kind_is_barrier(head_kind) || state_q.dne[state_q.head]);

    always_comb begin
        state_d = state_q;

        alloc_take  = alloc_valid && kind_legal(alloc_kind) && !ring_full &&
                      !(alloc_kind == OP_LOAD  && lq_full) &&
                      !(alloc_kind == OP_STORE && sq_full);
        retire_take = retire_valid && retire_ok;
        take_load   = alloc_take  && (alloc_kind == OP_LOAD);
        take_store  = alloc_take  && (alloc_kind == OP_STORE);
        free_load   = retire_take && (head_kind == OP_LOAD);
        free_store  = retire_take && (head_kind == OP_STORE);

        // entries granted this cycle are in execution from the next one
        state_d.iss = state_q.iss | issue_grant;

        if (opr_valid && tag_in_range(opr_tag) && state_q.vld[opr_tag])
            state_d.rdy[opr_tag] = 1'b1;

        if (cmpl_valid && tag_in_range(cmpl_tag) && state_q.vld[cmpl_tag] &&
            state_q.iss[cmpl_tag] && kind_is_memop(state_q.kind[cmpl_tag]))
            state_d.dne[cmpl_tag] = 1'b1;

        if (retire_take) begin
            state_d.vld[state_q.head] = 1'b0;
            state_d.rdy[state_q.head] = 1'b0;
            state_d.iss[state_q.head] = 1'b0;
            state_d.dne[state_q.head] = 1'b0;
            state_d.head              = ptr_next(state_q.head);
        end

        if (alloc_take) begin
            state_d.vld[state_q.tail]  = 1'b1;
            state_d.rdy[state_q.tail]  = alloc_ops_rdy;
            state_d.iss[state_q.tail]  = 1'b0;
            state_d.dne[state_q.tail]  = 1'b0;
            state_d.kind[state_q.tail] = alloc_kind;
            state_d.tail               = ptr_next(state_q.tail);
        end

        state_d.cnt  = state_q.cnt  + CNT_W'(alloc_take) - CNT_W'(retire_take);
        state_d.lcnt = state_q.lcnt + LQ_W'(take_load)   - LQ_W'(free_load);
        state_d.scnt = state_q.scnt + SQ_W'(take_store)  - SQ_W'(free_store);

        if (cfg_we)
            state_d.noalias = cfg_noalias;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q         <= '0;
            state_q.noalias <= 1'b1;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/memord_queue_chk.sv
module memord_queue_chk #(
    parameter int RING    = 8,
    parameter int IDX_W   = 3,
    parameter int ISSUE_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_valid,
    input logic [2:0]       alloc_kind,
    input logic [IDX_W-1:0] alloc_tag,
    input logic             lq_full,
    input logic             sq_full,
    input logic             ring_full,
    input logic [RING-1:0]  issue_perm,
    input logic [RING-1:0]  issue_grant,
    input logic             retire_valid,
    input logic             retire_ok,
    input logic [IDX_W-1:0] head_idx
);

    // R6
    grant_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_grant & ~issue_perm) == '0);

    // R6
    grant_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(issue_grant) <= ISSUE_W);

    // R6
    grant_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_grant != '0) |=> ((issue_grant & $past(issue_grant)) == '0));

    // R1
    lq_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lq_full && alloc_valid && alloc_kind == 3'd0) |=> $stable(alloc_tag));

    // R1
    sq_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_full && alloc_valid && alloc_kind == 3'd1) |=> $stable(alloc_tag));

    // R1
    ring_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_full && alloc_valid) |=> $stable(alloc_tag));

    // R7
    retire_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_valid && !retire_ok) |=> $stable(head_idx));

    // R7
    retire_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_valid && retire_ok) |=> !$stable(head_idx));

endmodule

bind memord_queue memord_queue_chk #(
    .RING    (RING),
    .IDX_W   (IDX_W),
    .ISSUE_W (ISSUE_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_valid  (alloc_valid),
    .alloc_kind   (alloc_kind),
    .alloc_tag    (alloc_tag),
    .lq_full      (lq_full),
    .sq_full      (sq_full),
    .ring_full    (ring_full),
    .issue_perm   (issue_perm),
    .issue_grant  (issue_grant),
    .retire_valid (retire_valid),
    .retire_ok    (retire_ok),
    .head_idx     (head_idx)
);

// File: tb/test_memord_queue.sv
module test_memord_queue;

    localparam int CLK_PERIOD = 10;
    localparam int LQ = 3;
    localparam int SQ = 2;
    localparam int IW = 2;
    localparam int RING = LQ + SQ;
    localparam int IDX_W = 3;

    localparam logic [2:0] K_LD = 3'd0, K_ST = 3'd1, K_LB = 3'd2, K_SB = 3'd3, K_FB = 3'd4;
    localparam int S_GRANT = 0, S_PERM = 1, S_TAG = 2, S_LQF = 3, S_SQF = 4, S_RF = 5, S_ROK = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0, cfg_noalias = 1'b0;
    logic             alloc_valid = 1'b0, alloc_ops_rdy = 1'b0;
    logic [2:0]       alloc_kind = 3'd0;
    logic [IDX_W-1:0] alloc_tag;
    logic             lq_full, sq_full, ring_full;
    logic             opr_valid = 1'b0, cmpl_valid = 1'b0, retire_valid = 1'b0;
    logic [IDX_W-1:0] opr_tag = '0, cmpl_tag = '0;
    logic [RING-1:0]  issue_perm, issue_grant;
    logic             retire_ok;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    int    q_tgt[$];
    int    q_sel[$];
    int    q_exp[$];
    string q_req[$];

    memord_queue #(
        .LQ_DEPTH (LQ),
        .SQ_DEPTH (SQ),
        .ISSUE_W  (IW)
    ) i_memord_queue (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we        (cfg_we),
        .cfg_noalias   (cfg_noalias),
        .alloc_valid   (alloc_valid),
        .alloc_kind    (alloc_kind),
        .alloc_ops_rdy (alloc_ops_rdy),
        .alloc_tag     (alloc_tag),
        .lq_full       (lq_full),
        .sq_full       (sq_full),
        .ring_full     (ring_full),
        .opr_valid     (opr_valid),
        .opr_tag       (opr_tag),
        .cmpl_valid    (cmpl_valid),
        .cmpl_tag      (cmpl_tag),
        .issue_perm    (issue_perm),
        .issue_grant   (issue_grant),
        .retire_valid  (retire_valid),
        .retire_ok     (retire_ok)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int sample(input int sel);
        case (sel)
            S_GRANT: return int'(issue_grant);
            S_PERM:  return int'(issue_perm);
            S_TAG:   return int'(alloc_tag);
            S_LQF:   return int'(lq_full);
            S_SQF:   return int'(sq_full);
            S_RF:    return int'(ring_full);
            default: return int'(retire_ok);
        endcase
    endfunction

    // monitor: compares queued expectations at the falling edge of their cycle
    initial begin
        forever begin
            @(negedge clk);
            while (q_tgt.size() > 0 && q_tgt[0] <= cyc) begin
                int    sel, exp_v, act;
                string req;
                sel = q_sel.pop_front();
                exp_v = q_exp.pop_front();
                req = q_req.pop_front();
                void'(q_tgt.pop_front());
                act = sample(sel);
                checks++;
                if (act != exp_v) begin
                    fails++;
                    $display("FAIL %s signal=%0d actual=%0h expected=%0h", req, sel, act, exp_v);
                end
            end
        end
    end

    task automatic expect_v(input int sel, input int v, input string req);
        q_tgt.push_back(cyc);
        q_sel.push_back(sel);
        q_exp.push_back(v);
        q_req.push_back(req);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
        alloc_valid = 1'b0;
        opr_valid = 1'b0;
        cmpl_valid = 1'b0;
        retire_valid = 1'b0;
    endtask

    task automatic alloc(input logic [2:0] k, input logic r);
        alloc_valid = 1'b1; alloc_kind = k; alloc_ops_rdy = r; tick();
    endtask
    task automatic opr(input int t);
        opr_valid = 1'b1; opr_tag = IDX_W'(t); tick();
    endtask
    task automatic cmpl(input int t);
        cmpl_valid = 1'b1; cmpl_tag = IDX_W'(t); tick();
    endtask
    task automatic retire();
        retire_valid = 1'b1; tick();
    endtask
    task automatic ret_cmpl(input int t);
        retire_valid = 1'b1; cmpl_valid = 1'b1; cmpl_tag = IDX_W'(t); tick();
    endtask
    task automatic set_mode(input logic v);
        cfg_we = 1'b1; cfg_noalias = v; tick();
    endtask
    task automatic idle();
        tick();
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not end, actual=hung expected=done");
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();
        // reset state
        expect_v(S_GRANT, 0, "R6 reset grant");
        expect_v(S_TAG, 0, "R9 reset tag");
        expect_v(S_LQF, 0, "R1 reset lq_full");
        expect_v(S_SQF, 0, "R1 reset sq_full");
        expect_v(S_RF, 0, "R1 reset ring_full");
        expect_v(S_ROK, 0, "R7 reset retire_ok");

        // A: default no-alias, load passes unready store
        alloc(K_ST, 1'b0);         expect_v(S_GRANT, 0, "R8 store without operands");
        alloc(K_LD, 1'b1);         expect_v(S_GRANT, 5'b00010, "R3 load passes store by default");
                                   expect_v(S_TAG, 2, "R9 tag order");
        idle();                    expect_v(S_GRANT, 0, "R6 granted once");
        retire();                  expect_v(S_ROK, 0, "R7 retire ignored");
        opr(0);                    expect_v(S_GRANT, 5'b00001, "R8 store after operand notice");
        idle();
        cmpl(0);                   expect_v(S_ROK, 1, "R7 head done");
        ret_cmpl(1);               expect_v(S_ROK, 1, "R7 next head done");
        retire();                  expect_v(S_ROK, 0, "R7 empty");
                                   expect_v(S_TAG, 2, "R9 tail kept");

        // B: alias mode, load waits for older store
        set_mode(1'b0);
        alloc(K_ST, 1'b0);
        alloc(K_LD, 1'b1);         expect_v(S_PERM, 0, "R3 load held by store");
        opr(2);                    expect_v(S_GRANT, 5'b00100, "R3 store first");
        idle();                    expect_v(S_GRANT, 5'b01000, "R3 load after store issued");
        idle();
        cmpl(2); ret_cmpl(3); retire();
        expect_v(S_TAG, 4, "R9 tag advance");

        // C: store waits for older load
        alloc(K_LD, 1'b0);
        alloc(K_ST, 1'b1);         expect_v(S_PERM, 0, "R4 store held by load");
        cmpl(4);                   expect_v(S_ROK, 0, "R7 unissued completion ignored");
        opr(4);                    expect_v(S_GRANT, 5'b10000, "R4 load first");
        idle();                    expect_v(S_GRANT, 5'b00001, "R4 store after load, wrapped slot");
        idle();
        cmpl(4); ret_cmpl(0); retire();
        expect_v(S_TAG, 1, "R9 wrap");
        set_mode(1'b1);

        // D: load barrier
        alloc(K_LD, 1'b0);
        alloc(K_LB, 1'b0);
        alloc(K_LD, 1'b1);
        alloc(K_ST, 1'b1);         expect_v(S_GRANT, 0, "R5 load behind load barrier");
        opr(1);                    expect_v(S_GRANT, 5'b00010, "R5 older load free");
        idle();                    expect_v(S_GRANT, 0, "R5 barrier not at head");
        cmpl(1);
        retire();                  expect_v(S_GRANT, 5'b01000, "R5 barrier at head executed");
                                   expect_v(S_ROK, 1, "R5 barrier retirable at head");
        idle();                    expect_v(S_GRANT, 5'b10000, "R4 store after load");
        retire(); cmpl(3); ret_cmpl(4); retire();
        expect_v(S_TAG, 0, "R9 tag");
        expect_v(S_ROK, 0, "R7 empty");

        // E: capacity and issue width
        set_mode(1'b0);
        alloc(K_ST, 1'b0);
        alloc(K_LD, 1'b1);
        alloc(K_LD, 1'b1);
        alloc(K_LD, 1'b1);         expect_v(S_LQF, 1, "R1 load capacity");
                                   expect_v(S_PERM, 0, "R3 loads held in alias mode");
        alloc(K_LD, 1'b1);         expect_v(S_TAG, 4, "R1 load ignored when full");
        alloc(K_SB, 1'b0);         expect_v(S_RF, 1, "R1 ring full");
                                   expect_v(S_TAG, 0, "R9 tail wraps");
        alloc(K_ST, 1'b1);         expect_v(S_TAG, 0, "R1 ignored when ring full");
                                   expect_v(S_SQF, 0, "R1 store count unchanged");
        opr(0);                    expect_v(S_GRANT, 5'b00001, "R4 store at head");
        idle();                    expect_v(S_GRANT, 5'b00110, "R6 oldest two of three");
                                   expect_v(S_PERM, 5'b01110, "R2 loads permitted together");
        idle();                    expect_v(S_GRANT, 5'b01000, "R6 remaining load");
        idle();
        cmpl(0); ret_cmpl(1); ret_cmpl(2); ret_cmpl(3);
        retire();                  expect_v(S_ROK, 1, "R5 store barrier at head");
        retire();                  expect_v(S_RF, 0, "R1 ring drained");
        set_mode(1'b1);

        // F: store ordering and full barrier
        alloc(K_ST, 1'b0);
        alloc(K_ST, 1'b0);         expect_v(S_SQF, 1, "R1 store capacity");
        alloc(K_ST, 1'b1);         expect_v(S_TAG, 2, "R1 store ignored when full");
        alloc(K_FB, 1'b0);
        alloc(K_LD, 1'b1);         expect_v(S_GRANT, 0, "R5 load behind full barrier");
        opr(1);                    expect_v(S_GRANT, 0, "R4 younger store waits");
        opr(0);                    expect_v(S_GRANT, 5'b00001, "R4 older store");
        idle();                    expect_v(S_GRANT, 5'b00010, "R4 younger store next");
        idle();                    expect_v(S_GRANT, 0, "R5 full barrier still pending");
        cmpl(0); ret_cmpl(1);
        retire();                  expect_v(S_GRANT, 5'b01000, "R5 full barrier at head");
        idle(); retire(); cmpl(3); retire();
        expect_v(S_TAG, 4, "R9 tag");

        // G: store barrier
        alloc(K_LD, 1'b1);         expect_v(S_GRANT, 5'b10000, "R2 lone load");
        alloc(K_SB, 1'b0);
        alloc(K_ST, 1'b1);         expect_v(S_PERM, 0, "R5 store behind store barrier");
        alloc(K_LD, 1'b1);         expect_v(S_GRANT, 5'b00100, "R5 load ignores store barrier");
        cmpl(4);
        retire();                  expect_v(S_GRANT, 5'b00010, "R5 store barrier at head");
        idle(); retire(); cmpl(1); ret_cmpl(2); retire();
        expect_v(S_ROK, 0, "R7 drained");

        repeat (3) @(posedge clk);
        summary();
    end

endmodule